// File: doc/BRIEF.md
# Network-Addressable UART Interrupt Identifier

This block holds the pending-interrupt flags of a UART with network addressing. It decides which pending source is reported to the host and produces a 4-bit identification word and an interrupt request. Event pulses come from the surrounding UART. Received bytes arrive already assembled, each with a flag that marks it as an address byte or a data byte. Single-cycle strobes stand for the host's register accesses, and each strobe clears the source that the matching access acknowledges.

The block adds two network sources to the four usual UART sources. The first is a match between an incoming address byte and a local 8-bit station address. The second is the completion of an outgoing address byte. The host reads the identification word to find the most urgent enabled source, services it, and the next pending source then appears in the word.

Top module: `nuart_irq_id`

## Requirements
- R1: When no enabled source is pending, `ident` reads 4'b0001 (bit 0 high, bits 3:1 zero). When any enabled source is pending, bit 0 reads 0.
- R2: `irq` is high exactly when `ident[0]` is low.
- R3: `ident[3:1]` carries the code of the reported source: address match 110, address sent 101, line status 011, receive full 010, transmit empty 001, modem status 000.
- R4: Reporting priority, highest first: line status, address match, receive full, address sent, transmit empty, modem status.
- R5: An accepted byte with `rx_is_addr`=1 that equals `addr_q` latches address match. An address byte that does not match latches nothing. A byte with `rx_is_addr`=0 latches receive full.
- R6: Address match is latched only if `ien[0]` is 1 in the cycle the matching byte arrives.
- R7: The enable bits are `ien[0]` for receive full and address match, `ien[1]` for transmit empty and address sent, `ien[2]` for line status, and `ien[3]` for modem status. A source whose enable is 0 keeps its pending flag but is not reported until it is enabled.
- R8: `rd_rxdata` clears receive full and address match. `wr_txdata` clears transmit empty and address sent. `rd_linestat` clears line status. `rd_modemstat` clears modem status. The next pending source is reported in the cycle after the clear.
- R9: `rd_ident` clears transmit empty or address sent only when that source is the one being reported at the time of the strobe.
- R10: If a source's event and its clear arrive in the same cycle, the source stays pending.
- R11: `addr_q` resets to 8'hAA and takes `addr_wdata` on a cycle with `addr_wr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien | input | 4 | Source enables (see R7) |
| rx_valid | input | 1 | Received byte strobe |
| rx_is_addr | input | 1 | Received byte is an address byte |
| rx_byte | input | 8 | Received byte value |
| addr_sent_evt | input | 1 | Outgoing address byte finished, transmit buffer empty |
| line_err_evt | input | 1 | Receive line status event |
| tx_empty_evt | input | 1 | Transmit buffer became empty |
| modem_evt | input | 1 | Modem status change |
| rd_rxdata | input | 1 | Host read of receive data |
| wr_txdata | input | 1 | Host write of transmit data |
| rd_ident | input | 1 | Host read of the identification word |
| rd_linestat | input | 1 | Host read of line status |
| rd_modemstat | input | 1 | Host read of modem status |
| addr_wr | input | 1 | Station address write strobe |
| addr_wdata | input | 8 | Station address write data |
| addr_q | output | 8 | Station address register |
| ident | output | 4 | Identification word: code in bits 3:1, not-pending flag in bit 0 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the idle word carries code 000 and that the request is the inverse of bit 0. They also check that a clear with no coincident event empties its flag, that an event always leaves its flag set, that at most one source is granted, that address match never rises without the receive enable, and that the address register returns to its reset value. Only the bench scenarios can show the full priority ranking between sources pending together and the order in which sources appear as they are cleared one by one. The same applies to the conditional clear by an identification read, the hiding and later reporting of a disabled source, and matching against a newly written station address.

// File: rtl/nuart_irq_pkg.sv
package nuart_irq_pkg;
    // pending-vector index, in reporting priority (0 = highest)
    localparam int NSRC     = 6;
    localparam int S_LINE   = 0;
    localparam int S_MATCH  = 1;
    localparam int S_RXFULL = 2;
    localparam int S_ASENT  = 3;
    localparam int S_TXEMP  = 4;
    localparam int S_MODEM  = 5;

    typedef enum logic [2:0] {
        CODE_MODEM  = 3'b000,
        CODE_TXEMP  = 3'b001,
        CODE_RXFULL = 3'b010,
        CODE_LINE   = 3'b011,
        CODE_ASENT  = 3'b101,
        CODE_MATCH  = 3'b110
    } src_code_e;

    function automatic src_code_e code_of(input int idx);
        case (idx)
            S_LINE:   return CODE_LINE;
            S_MATCH:  return CODE_MATCH;
            S_RXFULL: return CODE_RXFULL;
            S_ASENT:  return CODE_ASENT;
            S_TXEMP:  return CODE_TXEMP;
            default:  return CODE_MODEM;
        endcase
    endfunction
endpackage

// File: rtl/nuart_src_pending.sv
module nuart_src_pending #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pend = (st_q.pend & ~clr_i) | set_i;   // event wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !pend_o[i]);                 // R8
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> pend_o[i]);                                 // R10
    end
endmodule

// File: rtl/nuart_prio_enc.sv
module nuart_prio_enc
    import nuart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] grant_o,
    output logic [2:0]   code_o,
    output logic         any_o
);
    logic [N-1:0] live;
    assign live = pend_i & mask_i;

    always_comb begin
        grant_o = '0;
        code_o  = 3'b000;
        // scan from lowest priority up so the highest live source wins
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
                code_o  = code_of(i);
            end
        end
    end

    assign any_o = |live;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));                                          // R4
    AST_GRANT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> $countones(grant_o) == 1);                         // R4
endmodule

// File: rtl/nuart_irq_id.sv
module nuart_irq_id
    import nuart_irq_pkg::*;
#(
    parameter int          BYTE_W   = 8,
    parameter logic [7:0]  ADDR_RST = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ien,
    input  logic              rx_valid,
    input  logic              rx_is_addr,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              addr_sent_evt,
    input  logic              line_err_evt,
    input  logic              tx_empty_evt,
    input  logic              modem_evt,
    input  logic              rd_rxdata,
    input  logic              wr_txdata,
    input  logic              rd_ident,
    input  logic              rd_linestat,
    input  logic              rd_modemstat,
    input  logic              addr_wr,
    input  logic [BYTE_W-1:0] addr_wdata,
    output logic [BYTE_W-1:0] addr_q,
    output logic [3:0]        ident,
    output logic              irq
);
    typedef struct packed {
        logic [BYTE_W-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0] set_v, clr_v, mask_v, pend_v, grant_v;
    logic [2:0]      code;
    logic            any;
    logic            hit;

    assign hit = rx_valid && rx_is_addr && (rx_byte == st_q.addr);

    always_comb begin
        st_d = st_q;
        if (addr_wr) st_d.addr = addr_wdata;

        set_v = '0;
        set_v[S_LINE]   = line_err_evt;
        set_v[S_MATCH]  = hit && ien[0];
        set_v[S_RXFULL] = rx_valid && !rx_is_addr;
        set_v[S_ASENT]  = addr_sent_evt;
        set_v[S_TXEMP]  = tx_empty_evt;
        set_v[S_MODEM]  = modem_evt;

        clr_v = '0;
        clr_v[S_LINE]   = rd_linestat;
        clr_v[S_MATCH]  = rd_rxdata;
        clr_v[S_RXFULL] = rd_rxdata;
        clr_v[S_ASENT]  = wr_txdata || (rd_ident && grant_v[S_ASENT]);
        clr_v[S_TXEMP]  = wr_txdata || (rd_ident && grant_v[S_TXEMP]);
        clr_v[S_MODEM]  = rd_modemstat;

        mask_v = '0;
        mask_v[S_LINE]   = ien[2];
        mask_v[S_MATCH]  = ien[0];
        mask_v[S_RXFULL] = ien[0];
        mask_v[S_ASENT]  = ien[1];
        mask_v[S_TXEMP]  = ien[1];
        mask_v[S_MODEM]  = ien[3];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.addr <= ADDR_RST;
        else        st_q <= st_d;
    end

    nuart_src_pending #(.N(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .pend_o (pend_v)
    );

    nuart_prio_enc #(.N(NSRC)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend_v),
        .mask_i  (mask_v),
        .grant_o (grant_v),
        .code_o  (code),
        .any_o   (any)
    );

    assign addr_q = st_q.addr;
    assign ident  = {code, ~any};
    assign irq    = any;

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ident[0] |-> ident[3:1] == 3'b000);                          // R1
    AST_IRQ_INV: assert property (@(posedge clk) disable iff (!rst_n)
        irq != ident[0]);                                            // R2
    AST_MATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_v[S_MATCH]) |-> $past(ien[0]));                   // R6
    AST_ADDR_RESET: assert property (@(posedge clk)
        !rst_n |=> addr_q == ADDR_RST);                              // R11
endmodule

// File: tb/tb_nuart_irq_id.sv
module tb_nuart_irq_id;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ien = 4'h0;
    logic       rx_valid = 0, rx_is_addr = 0;
    logic [7:0] rx_byte = 8'h00;
    logic       addr_sent_evt = 0, line_err_evt = 0, tx_empty_evt = 0, modem_evt = 0;
    logic       rd_rxdata = 0, wr_txdata = 0, rd_ident = 0, rd_linestat = 0, rd_modemstat = 0;
    logic       addr_wr = 0;
    logic [7:0] addr_wdata = 8'h00;
    logic [7:0] addr_q;
    logic [3:0] ident;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] station = 8'hAA;

    always #4 clk = ~clk;   // 125 MHz

    nuart_irq_id dut (
        .clk(clk), .rst_n(rst_n), .ien(ien),
        .rx_valid(rx_valid), .rx_is_addr(rx_is_addr), .rx_byte(rx_byte),
        .addr_sent_evt(addr_sent_evt), .line_err_evt(line_err_evt),
        .tx_empty_evt(tx_empty_evt), .modem_evt(modem_evt),
        .rd_rxdata(rd_rxdata), .wr_txdata(wr_txdata), .rd_ident(rd_ident),
        .rd_linestat(rd_linestat), .rd_modemstat(rd_modemstat),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .addr_q(addr_q), .ident(ident), .irq(irq)
    );

    // {ien[3:0], ev{line,data,addr,asent,tx,modem}, clr{rrx,wtx,rid,rls,rms}, exp_ident[3:0]}
    localparam int NV = 28;
    localparam logic [18:0] VECS [0:NV-1] = '{
        {4'hF, 6'b000001, 5'b00000, 4'b0000},  // R3 modem
        {4'hF, 6'b000010, 5'b00000, 4'b0010},  // R4 tx over modem
        {4'hF, 6'b010000, 5'b00000, 4'b0100},  // R5 data byte -> rx full
        {4'hF, 6'b100000, 5'b00000, 4'b0110},  // R4 line on top
        {4'hF, 6'b000000, 5'b00010, 4'b0100},  // R8 rd_linestat
        {4'hF, 6'b000000, 5'b10000, 4'b0010},  // R8 rd_rxdata
        {4'hF, 6'b000000, 5'b00100, 4'b0000},  // R9 rd_ident clears shown tx
        {4'hF, 6'b000000, 5'b00001, 4'b0001},  // R8 rd_modemstat, R1 idle
        {4'hF, 6'b000100, 5'b00000, 4'b1010},  // R3 address sent
        {4'hF, 6'b000010, 5'b00000, 4'b1010},  // R4 asent above tx
        {4'hF, 6'b000000, 5'b00100, 4'b0010},  // R9 rd_ident clears shown asent only
        {4'hF, 6'b000000, 5'b01000, 4'b0001},  // R8 wr_txdata
        {4'hF, 6'b001000, 5'b00000, 4'b1100},  // R5 address match
        {4'hF, 6'b010000, 5'b00000, 4'b1100},  // R4 match above rx full
        {4'hF, 6'b100000, 5'b00000, 4'b0110},  // R4 line above match
        {4'hF, 6'b000000, 5'b00010, 4'b1100},  // R8 next shown next cycle
        {4'hF, 6'b000000, 5'b10000, 4'b0001},  // R8 rd_rxdata clears both
        {4'h0, 6'b001000, 5'b00000, 4'b0001},  // R6 match with ien[0]=0
        {4'hF, 6'b000000, 5'b00000, 4'b0001},  // R6 match not latched
        {4'hE, 6'b010000, 5'b00000, 4'b0001},  // R7 rx full hidden
        {4'hF, 6'b000000, 5'b00000, 4'b0100},  // R7 shown once enabled
        {4'hF, 6'b000000, 5'b10000, 4'b0001},  // R8
        {4'hF, 6'b100010, 5'b00000, 4'b0110},  // R4
        {4'hF, 6'b000000, 5'b00100, 4'b0110},  // R9 rd_ident with tx not shown
        {4'hF, 6'b000000, 5'b00010, 4'b0010},  // R9 tx survived
        {4'hF, 6'b000000, 5'b01000, 4'b0001},  // R8
        {4'hF, 6'b010000, 5'b10000, 4'b0100},  // R10 set wins over clear
        {4'hF, 6'b000000, 5'b10000, 4'b0001}   // R10 then clears
    };

    task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rx_valid = 0; rx_is_addr = 0; rx_byte = 8'h00;
        addr_sent_evt = 0; line_err_evt = 0; tx_empty_evt = 0; modem_evt = 0;
        rd_rxdata = 0; wr_txdata = 0; rd_ident = 0; rd_linestat = 0; rd_modemstat = 0;
        addr_wr = 0;
    endtask

    task automatic send_byte(input logic is_addr, input logic [7:0] b);
        rx_valid = 1; rx_is_addr = is_addr; rx_byte = b;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1 R2 R11: reset state
        check4("R1 reset ident", ident, 4'b0001);
        check4("R2 reset irq", {3'b000, irq}, 4'b0000);
        check8("R11 reset addr", addr_q, 8'hAA);
        rst_n = 1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [18:0] e;
            e = VECS[v];
            ien = e[18:15];
            line_err_evt = e[14];
            if (e[13]) begin rx_valid = 1; rx_is_addr = 0; rx_byte = 8'h33; end
            if (e[12]) begin rx_valid = 1; rx_is_addr = 1; rx_byte = station; end
            addr_sent_evt = e[11];
            tx_empty_evt  = e[10];
            modem_evt     = e[9];
            rd_rxdata     = e[8];
            wr_txdata     = e[7];
            rd_ident      = e[6];
            rd_linestat   = e[5];
            rd_modemstat  = e[4];
            @(negedge clk);
            idle_inputs();
            check4($sformatf("R3/R4 vector %0d ident", v), ident, e[3:0]);
            check4($sformatf("R2 vector %0d irq", v), {3'b000, irq}, {3'b000, ~e[0]});
        end

        // R11: address write, then R5 matching against the new address
        ien = 4'hF;
        addr_wr = 1; addr_wdata = 8'h5C;
        @(negedge clk);
        idle_inputs();
        station = 8'h5C;
        check8("R11 written addr", addr_q, 8'h5C);
        send_byte(1'b1, 8'hAA);
        check4("R5 non-matching address byte", ident, 4'b0001);
        send_byte(1'b1, 8'h5C);
        check4("R5 new address matches", ident, 4'b1100);

        // reset mid-run clears pending and restores address
        rst_n = 0;
        @(negedge clk);
        check4("R1 pending cleared by reset", ident, 4'b0001);
        check8("R11 addr back to reset value", addr_q, 8'hAA);
        rst_n = 1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule